// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is a single inter-thread communication cell that buffers 64-bit words in first-in, first-out order. A requester presents one access per cycle together with a two-bit view code and a thread number. The view code selects how the same storage is treated: direct (bypass) access to the head and tail words, access to the cell's tag, or empty/full-synchronised pushes and pops in either a blocking or a non-blocking flavour.

The tag holds an empty flag, a full flag, a software trap flag, a constant FIFO-type flag, the entry count and a depth code. When a blocking pop meets an empty cell, or a blocking push meets a full one, the cell answers "blocked" and records the thread in a waiter mask. The next empty/full access that does proceed reports the whole mask on a one-cycle wake pulse and clears it. Halting or restarting threads is left to the surrounding logic.

Top module: `fifo_comm_cell`

## Requirements
- R1: After reset a tag read returns empty=1 (bit 0), full=0 (bit 1), trap=0 (bit 16), FIFO-type=1 (bit 17), count=0 (bits starting at 18) and log2(DEPTH) in the 4-bit field at bits 31:28; no other bit is set.
- R2: A tag write (view 1) loads trap, empty and full from data bits 16, 0 and 1; when data bit 0 is 1 the count becomes 0 and the stored words stay in place.
- R3: An empty/full push (view 2 blocking, view 3 non-blocking) clears empty and, if count < DEPTH, appends the word and increments count; full is set when count reaches DEPTH. A non-blocking push on a full cell stores nothing and leaves count at DEPTH.
- R4: An empty/full pop clears full and, if count > 0, returns the oldest word and decrements count; empty is set when count becomes 0.
- R5: A non-blocking pop (view 3) with count 0 returns 0, is not blocked, and leaves count at 0.
- R6: A blocking pop while empty is set returns 0 with blocked asserted, stores the requesting thread's bit in the waiter mask, and still clears full.
- R7: A blocking push while full is set is answered blocked, stores nothing, records the thread, and still clears empty.
- R8: An empty/full access that is not blocked while the waiter mask is non-zero pulses wake for one response with the full mask, and clears the mask.
- R9: A bypass read (view 0) returns the oldest word without changing count or order.
- R10: A bypass write overwrites the newest word when count > 0 and is ignored when count is 0.
- R11: Read and write positions wrap modulo DEPTH, so FIFO order holds for any starting position.
- R12: Every response (valid, data, blocked, wake, wake mask) appears exactly one cycle after the request and valid lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| view_i | input | 2 | 0 bypass, 1 tag, 2 blocking empty/full, 3 non-blocking empty/full |
| thread_i | input | TID_W | Number of the requesting thread |
| wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rdata_o | output | DW | Read data (0 for writes and blocked accesses) |
| blocked_o | output | 1 | Access was blocked |
| wake_o | output | 1 | Waiters released by this access |
| wake_mask_o | output | NTHREADS | Threads released |

## Verification
All results are registered once, so data, blocked, wake and mask for an access are due on the first rising edge after the request is presented, and the tag effect of an access is visible to the very next tag read. The bench drives each request on a falling edge, lets one rising edge pass and reads the response on the following falling edge, which is also where the next request is driven. Fill-and-drain rounds start from shifted positions to cover pointer wrap, and the waiter scenarios check the wake mask on the exact response that releases it.

// File: rtl/fifo_cell_pkg.sv
package fifo_cell_pkg;
  typedef enum logic [1:0] {
    VIEW_BYPASS = 2'd0,
    VIEW_TAG    = 2'd1,
    VIEW_EF_BLK = 2'd2,
    VIEW_EF_TRY = 2'd3
  } view_e;

  localparam int unsigned TAG_E_BIT     = 0;
  localparam int unsigned TAG_F_BIT     = 1;
  localparam int unsigned TAG_T_BIT     = 16;
  localparam int unsigned TAG_FIFO_BIT  = 17;
  localparam int unsigned TAG_CNT_LSB   = 18;
  localparam int unsigned TAG_DCODE_LSB = 28;
  localparam int unsigned DCODE_W       = 4;
endpackage

// File: rtl/cell_decode.sv
module cell_decode
  import fifo_cell_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             req_i,
  input  logic             we_i,
  input  view_e            view_i,
  input  logic             e_i,
  input  logic             f_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             waiters_nz_i,
  output logic             ef_rd_o,
  output logic             ef_wr_o,
  output logic             tag_wr_o,
  output logic             byp_wr_o,
  output logic             block_o,
  output logic             wake_o,
  output logic             pop_o,
  output logic             push_o
);
  logic ef, blk_view, proceed;

  always_comb begin
    ef       = req_i && (view_i == VIEW_EF_BLK || view_i == VIEW_EF_TRY);
    blk_view = (view_i == VIEW_EF_BLK);
    ef_rd_o  = ef && !we_i;
    ef_wr_o  = ef && we_i;
    tag_wr_o = req_i && we_i && (view_i == VIEW_TAG);
    byp_wr_o = req_i && we_i && (view_i == VIEW_BYPASS) && (cnt_i != '0);
    // flag test uses the pre-access value; the opposite flag is cleared first
    block_o  = blk_view && ((ef_rd_o && e_i) || (ef_wr_o && f_i));
    proceed  = ef && !block_o;
    wake_o   = proceed && waiters_nz_i;
    pop_o    = proceed && !we_i && (cnt_i != '0);
    push_o   = proceed && we_i && (cnt_i != CNT_W'(DEPTH));
  end
endmodule

// File: rtl/cell_tag.sv
module cell_tag #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tag_wr_i,
  input  logic             wd_t_i,
  input  logic             wd_e_i,
  input  logic             wd_f_i,
  input  logic             ef_rd_i,
  input  logic             ef_wr_i,
  input  logic             block_i,
  input  logic             pop_i,
  input  logic             push_i,
  output logic             e_o,
  output logic             f_o,
  output logic             t_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PTR_W-1:0] rd_ptr_o
);
  logic             e_q, f_q, t_q, e_d, f_d, t_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] rd_q, rd_d;

  always_comb begin
    e_d = e_q; f_d = f_q; t_d = t_q; cnt_d = cnt_q; rd_d = rd_q;
    if (tag_wr_i) begin
      t_d = wd_t_i;
      e_d = wd_e_i;
      f_d = wd_f_i;
      if (wd_e_i) cnt_d = '0;
    end
    if (ef_rd_i) begin
      f_d = 1'b0;
      if (!block_i) begin
        if (pop_i) begin
          cnt_d = cnt_q - 1'b1;
          rd_d  = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
        end
        if (cnt_d == '0) e_d = 1'b1;
      end
    end
    if (ef_wr_i) begin
      e_d = 1'b0;
      if (!block_i) begin
        if (push_i) cnt_d = cnt_q + 1'b1;
        if (cnt_d == CNT_W'(DEPTH)) f_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q <= 1'b1; f_q <= 1'b0; t_q <= 1'b0; cnt_q <= '0; rd_q <= '0;
    end else begin
      e_q <= e_d; f_q <= f_d; t_q <= t_d; cnt_q <= cnt_d; rd_q <= rd_d;
    end
  end

  assign e_o = e_q;
  assign f_o = f_q;
  assign t_o = t_q;
  assign cnt_o = cnt_q;
  assign rd_ptr_o = rd_q;

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_last_pop_sets_e_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q == CNT_W'(1)) |=> (e_q && cnt_q == '0));
  assert_last_push_sets_f_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt_q == CNT_W'(DEPTH - 1)) |=> f_q);
  assert_blocked_keeps_cnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_i && !tag_wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cell_store.sv
module cell_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 64,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             byp_wr_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    head_o
);
  localparam int unsigned SW = PTR_W + 1;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [SW-1:0]    sum;
  logic [SW-1:0]    wrap;
  logic [PTR_W-1:0] widx;

  // push goes one past the newest entry, bypass write hits the newest
  always_comb begin
    sum  = SW'(rd_ptr_i) + SW'(cnt_i) - (byp_wr_i ? SW'(1) : SW'(0));
    wrap = (sum >= SW'(DEPTH)) ? sum - SW'(DEPTH) : sum;
    widx = wrap[PTR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i || byp_wr_i) begin
      mem_q[widx] <= wdata_i;
    end
  end

  assign head_o = mem_q[rd_ptr_i];

  assert_byp_needs_entry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_wr_i |-> (cnt_i != '0));
endmodule

// File: rtl/cell_waiters.sv
module cell_waiters #(
  parameter int unsigned NTHREADS = 4,
  parameter int unsigned TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                block_i,
  input  logic                wake_i,
  input  logic [TID_W-1:0]    thread_i,
  output logic [NTHREADS-1:0] mask_o,
  output logic                nz_o
);
  logic [NTHREADS-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wake_i) mask_d = '0;
    if (block_i) mask_d[thread_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign nz_o   = (mask_q != '0);

  assert_block_records_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |=> mask_q[$past(thread_i)]);
  assert_wake_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !block_i) |=> (mask_q == '0));
endmodule

// File: rtl/fifo_comm_cell.sv
module fifo_comm_cell
  import fifo_cell_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned DW       = 64,
  parameter int unsigned NTHREADS = 4,
  localparam int unsigned TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [1:0]          view_i,
  input  logic [TID_W-1:0]    thread_i,
  input  logic [DW-1:0]       wdata_i,
  output logic                rsp_valid_o,
  output logic [DW-1:0]       rdata_o,
  output logic                blocked_o,
  output logic                wake_o,
  output logic [NTHREADS-1:0] wake_mask_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned DCODE = $clog2(DEPTH);

  view_e               view;
  logic                e, f, t, waiters_nz;
  logic [CNT_W-1:0]    cnt;
  logic [PTR_W-1:0]    rd_ptr;
  logic                ef_rd, ef_wr, tag_wr, byp_wr, block, wake, pop, push;
  logic [DW-1:0]       head, tag_word, rdata_d;
  logic [NTHREADS-1:0] waiters;

  assign view = view_e'(view_i);

  cell_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_decode (
    .req_i(req_i), .we_i(we_i), .view_i(view), .e_i(e), .f_i(f), .cnt_i(cnt),
    .waiters_nz_i(waiters_nz), .ef_rd_o(ef_rd), .ef_wr_o(ef_wr),
    .tag_wr_o(tag_wr), .byp_wr_o(byp_wr), .block_o(block), .wake_o(wake),
    .pop_o(pop), .push_o(push)
  );

  cell_tag #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_tag (
    .clk_i(clk_i), .rst_ni(rst_ni), .tag_wr_i(tag_wr),
    .wd_t_i(wdata_i[TAG_T_BIT]), .wd_e_i(wdata_i[TAG_E_BIT]), .wd_f_i(wdata_i[TAG_F_BIT]),
    .ef_rd_i(ef_rd), .ef_wr_i(ef_wr), .block_i(block), .pop_i(pop), .push_i(push),
    .e_o(e), .f_o(f), .t_o(t), .cnt_o(cnt), .rd_ptr_o(rd_ptr)
  );

  cell_store #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .byp_wr_i(byp_wr),
    .rd_ptr_i(rd_ptr), .cnt_i(cnt), .wdata_i(wdata_i), .head_o(head)
  );

  cell_waiters #(.NTHREADS(NTHREADS), .TID_W(TID_W)) u_waiters (
    .clk_i(clk_i), .rst_ni(rst_ni), .block_i(block), .wake_i(wake),
    .thread_i(thread_i), .mask_o(waiters), .nz_o(waiters_nz)
  );

  always_comb begin
    tag_word = '0;
    tag_word[TAG_E_BIT]    = e;
    tag_word[TAG_F_BIT]    = f;
    tag_word[TAG_T_BIT]    = t;
    tag_word[TAG_FIFO_BIT] = 1'b1;
    tag_word[TAG_CNT_LSB +: CNT_W]     = cnt;
    tag_word[TAG_DCODE_LSB +: DCODE_W] = DCODE_W'(DCODE);
  end

  always_comb begin
    rdata_d = '0;
    if (req_i && !we_i) begin
      unique case (view)
        VIEW_BYPASS: rdata_d = head;
        VIEW_TAG:    rdata_d = tag_word;
        default:     rdata_d = pop ? head : '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rdata_o     <= '0;
      blocked_o   <= 1'b0;
      wake_o      <= 1'b0;
      wake_mask_o <= '0;
    end else begin
      rsp_valid_o <= req_i;
      rdata_o     <= rdata_d;
      blocked_o   <= block;
      wake_o      <= wake;
      wake_mask_o <= wake ? waiters : '0;
    end
  end

  assert_rsp_next_cycle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  assert_empty_blk_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && view == VIEW_EF_BLK && e) |=> (blocked_o && rdata_o == '0));
  assert_try_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && view == VIEW_EF_TRY && cnt == '0) |=> (!blocked_o && rdata_o == '0));
  assert_wake_has_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (wake_mask_o != '0));
endmodule

// File: tb/fifo_comm_cell_bench.sv
module fifo_comm_cell_bench;
  localparam int DEPTH = 8;
  localparam int NT    = 4;
  localparam int DCODE = $clog2(DEPTH);
  localparam logic [1:0] V_BYP = 2'd0, V_TAG = 2'd1, V_BLK = 2'd2, V_TRY = 2'd3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  view = 2'd0;
  logic [1:0]  tid = 2'd0;
  logic [63:0] wdata = '0;
  logic        rsp_valid, blocked, wake;
  logic [63:0] rdata;
  logic [NT-1:0] wmask;

  fifo_comm_cell #(.DEPTH(DEPTH), .DW(64), .NTHREADS(NT)) u_fifo_comm_cell (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .view_i(view),
    .thread_i(tid), .wdata_i(wdata), .rsp_valid_o(rsp_valid), .rdata_o(rdata),
    .blocked_o(blocked), .wake_o(wake), .wake_mask_o(wmask)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];
  bit m_t = 0, m_e = 1, m_f = 0;
  logic        r_vld, r_blk, r_wake;
  logic [63:0] r_data;
  logic [NT-1:0] r_mask;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] tagw(int cnt, bit t, bit f, bit e);
    return (64'(DCODE) << 28) | (64'(cnt) << 18) | (64'd1 << 17) |
           (64'(t) << 16) | (64'(f) << 1) | 64'(e);
  endfunction

  // called at a falling edge; returns at the falling edge after the response edge
  task automatic acc(logic [1:0] v, logic w, logic [63:0] d, int th);
    req = 1'b1; we = w; view = v; wdata = d; tid = 2'(th);
    @(posedge clk);
    @(negedge clk);
    r_vld = rsp_valid; r_data = rdata; r_blk = blocked; r_wake = wake; r_mask = wmask;
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic tag_chk(string rq);
    acc(V_TAG, 1'b0, '0, 0);
    chk(rq, r_data, tagw(exp_q.size(), m_t, m_f, m_e));
  endtask

  task automatic mpush(logic [63:0] d);
    m_e = 0;
    if (exp_q.size() < DEPTH) exp_q.push_back(d);
    if (exp_q.size() == DEPTH) m_f = 1;
  endtask

  task automatic mpop(output logic [63:0] d);
    m_f = 0;
    d = '0;
    if (exp_q.size() > 0) d = exp_q.pop_front();
    if (exp_q.size() == 0) m_e = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] e, a_word;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12 / R1: idle outputs and reset tag
    chk("R12 idle valid", 64'(rsp_valid), 64'd0);
    tag_chk("R1 reset tag");
    chk("R12 valid after request", 64'(r_vld), 64'd1);
    @(negedge clk);
    chk("R12 valid one cycle", 64'(rsp_valid), 64'd0);

    for (int r = 0; r < 4; r++) begin
      logic [1:0] ef_v;
      ef_v = r[0] ? V_BLK : V_TRY;
      // R11: shift the head position before each round
      for (int k = 0; k < r + 3; k++) begin
        logic [63:0] d;
        d = 64'hA000 + 64'(r * 16 + k);
        acc(V_TRY, 1'b1, d, 0); mpush(d);
        acc(V_TRY, 1'b0, '0, 0); mpop(e);
        chk("R11 shift pop", r_data, e);
      end
      for (int i = 0; i < DEPTH; i++) begin
        logic [63:0] d;
        d = {32'(r + 1), 32'(i * 32'h0101_0101 + 7)};
        acc(ef_v, 1'b1, d, 0); mpush(d);
        chk("R3 push not blocked", 64'(r_blk), 64'd0);
        chk("R3 push rdata", r_data, 64'd0);
      end
      tag_chk("R3 full tag");
      acc(V_TRY, 1'b1, 64'hDEAD, 1); mpush(64'hDEAD);
      chk("R3 try push on full not blocked", 64'(r_blk), 64'd0);
      tag_chk("R3 full count held");
      acc(V_BYP, 1'b0, '0, 0);
      chk("R9 bypass read head", r_data, exp_q[0]);
      tag_chk("R9 bypass read no pop");
      acc(V_BYP, 1'b1, 64'hB0B0_0000 + 64'(r), 0);
      exp_q[exp_q.size() - 1] = 64'hB0B0_0000 + 64'(r);
      for (int i = 0; i < DEPTH; i++) begin
        acc(ef_v, 1'b0, '0, 0); mpop(e);
        chk("R4 R11 R10 pop order", r_data, e);
        chk("R4 pop wake", 64'(r_wake), 64'd0);
      end
      tag_chk("R4 drained tag");
      acc(V_TRY, 1'b0, '0, 2); mpop(e);
      chk("R5 empty try pop data", r_data, 64'd0);
      chk("R5 empty try pop not blocked", 64'(r_blk), 64'd0);
      tag_chk("R5 count stays zero");
    end

    // R6 / R8: two blocked readers released by a push
    acc(V_BLK, 1'b0, '0, 2); m_f = 0;
    chk("R6 blocked", 64'(r_blk), 64'd1);
    chk("R6 blocked data", r_data, 64'd0);
    acc(V_BLK, 1'b0, '0, 1);
    chk("R6 second blocked", 64'(r_blk), 64'd1);
    tag_chk("R6 tag unchanged");
    acc(V_TRY, 1'b1, 64'h1234_5678, 0); mpush(64'h1234_5678);
    chk("R8 wake", 64'(r_wake), 64'd1);
    chk("R8 wake mask", 64'(r_mask), 64'b0110);
    acc(V_TRY, 1'b0, '0, 0); mpop(e);
    chk("R8 data after wake", r_data, e);
    chk("R8 mask cleared", 64'(r_wake), 64'd0);

    // R7: blocked writer on a full cell
    for (int i = 0; i < DEPTH; i++) begin
      acc(V_TRY, 1'b1, 64'hC000 + 64'(i), 0); mpush(64'hC000 + 64'(i));
    end
    acc(V_BLK, 1'b1, 64'hFFFF_EEEE, 3); m_e = 0;
    chk("R7 push blocked", 64'(r_blk), 64'd1);
    tag_chk("R7 tag after blocked push");
    acc(V_TRY, 1'b0, '0, 0); mpop(e);
    chk("R8 pop releases writer", 64'(r_mask), 64'b1000);
    chk("R8 pop data", r_data, e);
    while (exp_q.size() > 0) begin
      acc(V_TRY, 1'b0, '0, 0); mpop(e);
      chk("R7 blocked word not stored", r_data, e);
    end

    // R2 / R10: tag writes and ignored bypass write
    acc(V_TRY, 1'b1, 64'hAAAA, 0); mpush(64'hAAAA);
    a_word = 64'hAAAA;
    acc(V_TRY, 1'b1, 64'hBBBB, 0); mpush(64'hBBBB);
    acc(V_TAG, 1'b1, (64'd1 << 16) | 64'd2, 0); m_t = 1; m_f = 1; m_e = 0;
    tag_chk("R2 tag write T F");
    acc(V_TAG, 1'b1, 64'd1, 0); m_t = 0; m_f = 0; m_e = 1; exp_q.delete();
    tag_chk("R2 tag write E clears count");
    acc(V_BYP, 1'b1, 64'h5555, 0);
    acc(V_BYP, 1'b0, '0, 0);
    chk("R10 bypass write ignored at count 0", r_data, a_word);
    tag_chk("R10 count still zero");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule